// File: doc/BRIEF.md
# Word Copy Until Duplicate

This block copies 16-bit words from one region of memory to another and stops early on a repeat. Software, or a sequencing block, loads four values with a start pulse: a word count, an even source byte address, an even destination byte address and a compare word. The engine then reads the word at the source address. If that word equals the compare word, the copy stops. Otherwise the word is written to the destination, it becomes the new compare word, both addresses advance by one word and the count drops by one. This repeats until a duplicate is met or the count runs out.

When the copy ends, the block holds the remaining count and the current source and destination addresses on its outputs. It pulses `done` and reports the cause of termination in a two-bit code. The compare word is not returned. The memory side is a single request/ready port shared by reads and writes, and the engine stalls for as long as `mem_ready` is low.

Top module: `dupstop_copier`

## Requirements
- R1: A start pulse is accepted only while `busy` is low; it loads count, source, destination and compare word and raises `busy` on the next cycle; a start pulse while `busy` is high has no effect on the operation or its results.
- R2: For each moved word the engine reads address `src`, then writes that same value to address `dst`; after the write `src_out` and `dst_out` each rise by 2 and `cnt_out` falls by 1.
- R3: The compare word is replaced by every word moved. A read word equal to the compare word is not written, ends the copy with `end_code` 2, and leaves `src_out` pointing at that word with `cnt_out` and `dst_out` unchanged.
- R4: When the count reaches zero after a write, the copy ends with `end_code` 1 and `cnt_out` 0. A start with count 0 and even addresses ends with `end_code` 1 and makes no memory request.
- R5: If bit 0 of the source or destination address is 1 at start, the copy ends with `end_code` 3 and makes no memory request, and the outputs keep the loaded values. This check takes priority over a zero count.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. A transfer happens in a cycle where both `mem_req` and `mem_ready` are high. Read data is taken from `mem_rdata` in that cycle, and `mem_we` 0 marks a read and 1 a write.
- R7: `done` is high for exactly one cycle, in the cycle after the final transfer (or after the accepting start edge when no transfer is made). `busy` falls in the following cycle, and `end_code`, `cnt_out`, `src_out` and `dst_out` stay stable until the next accepted start.
- R8: After reset `busy`, `done` and `mem_req` are 0, `end_code` is 0 and the count and address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy with the load values |
| cnt_in | input | 16 | Initial word count |
| src_in | input | 32 | Initial source byte address |
| dst_in | input | 32 | Initial destination byte address |
| cmp_in | input | 16 | Initial compare word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| end_code | output | 2 | 0 none, 1 count zero, 2 duplicate, 3 misaligned |
| cnt_out | output | 16 | Remaining count |
| src_out | output | 32 | Current source byte address |
| dst_out | output | 32 | Current destination byte address |

## Verification
Some properties are checked by the assertions on every cycle. Request signals must hold during a stall, and `done` must never last two cycles. A duplicate read must be followed at once by the end pulse with code 2, and a misaligned start must finish with no request. Each non-duplicate read must load the compare word, the distance between source and destination must stay fixed, and a count-zero end must show a zero count. Other behaviour only the bench scenarios can show. These cover the words actually copied into memory and the exact final count and addresses against an independent model. They also cover the number of reads and writes, a start pulse ignored mid-copy, results that hold after the pulse, and address carries across high bits.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2,
    S_DONE  = 2'd3
  } dsc_state_t;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_ZERO  = 2'd1,
    END_DUP   = 2'd2,
    END_ALIGN = 2'd3
  } dsc_end_t;
endpackage

// File: rtl/dsc_regs.sv
module dsc_regs #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cnt_ld,
  input  logic [AW-1:0] src_ld,
  input  logic [AW-1:0] dst_ld,
  input  logic [DW-1:0] cmp_ld,
  input  logic          step,
  input  logic          capture,
  input  logic [DW-1:0] rd_word,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [DW-1:0] cmp_q,
  output logic          cnt_last,
  output logic          ld_zero,
  output logic          ld_misaligned
);
  localparam int BYTES_PER_WORD = DW / 8;

  function automatic logic [AW-1:0] adv_addr(input logic [AW-1:0] a);
    return a + AW'(BYTES_PER_WORD);
  endfunction

  function automatic logic [CW-1:0] dec_cnt(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic is_odd_pair(input logic [AW-1:0] s, input logic [AW-1:0] d);
    return s[0] | d[0];
  endfunction

  assign cnt_last      = (cnt_q == CW'(1));
  assign ld_zero       = (cnt_ld == '0);
  assign ld_misaligned = is_odd_pair(src_ld, dst_ld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cmp_q <= '0;
    end else if (load) begin
      cnt_q <= cnt_ld;
      src_q <= src_ld;
      dst_q <= dst_ld;
      cmp_q <= cmp_ld;
    end else begin
      if (step) begin
        cnt_q <= dec_cnt(cnt_q);
        src_q <= adv_addr(src_q);
        dst_q <= adv_addr(dst_q);
      end
      if (capture) begin
        cmp_q <= rd_word;
      end
    end
  end

  // R2: source and destination move in lock step
  a_r2_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((dst_q - src_q) == $past(dst_q - src_q)));

  // R2: a step never happens on an empty count
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q != '0));
endmodule

// File: rtl/dsc_cmp.sv
module dsc_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] cmp_word,
  output logic          dup_hit
);
  logic [DW-1:0] diff_bits;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_bit
      assign diff_bits[gi] = rd_word[gi] ^ cmp_word[gi];
    end
  endgenerate

  assign dup_hit = (diff_bits == '0);
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ld_zero,
  input  logic       ld_misaligned,
  input  logic       rd_fire,
  input  logic       wr_fire,
  input  logic       dup_hit,
  input  logic       cnt_last,
  output dsc_state_t state,
  output logic       load,
  output logic       capture,
  output logic       step,
  output logic [1:0] end_code
);
  dsc_end_t end_q;

  assign load     = (state == S_IDLE) && start;
  assign capture  = rd_fire && !dup_hit;
  assign step     = wr_fire;
  assign end_code = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      end_q <= END_NONE;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (ld_misaligned) begin
              end_q <= END_ALIGN;
              state <= S_DONE;
            end else if (ld_zero) begin
              end_q <= END_ZERO;
              state <= S_DONE;
            end else begin
              end_q <= END_NONE;
              state <= S_READ;
            end
          end
        end
        S_READ: begin
          if (rd_fire) begin
            if (dup_hit) begin
              end_q <= END_DUP;
              state <= S_DONE;
            end else begin
              state <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (wr_fire) begin
            if (cnt_last) begin
              end_q <= END_ZERO;
              state <= S_DONE;
            end else begin
              state <= S_READ;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: the end state lasts one cycle and returns to idle
  a_r7_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) |=> (state == S_IDLE));

  // R1: a start outside idle leaves the state path alone
  a_r1_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && start && !rd_fire) |=> (state == S_READ));
endmodule

// File: rtl/dupstop_copier.sv
module dupstop_copier
  import dsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [DW-1:0] cmp_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic [1:0]    end_code,
  output logic [CW-1:0] cnt_out,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out
);
  dsc_state_t    state;
  logic          load, capture, step;
  logic          rd_fire, wr_fire;
  logic          dup_hit, cnt_last, ld_zero, ld_misaligned;
  logic [DW-1:0] cmp_word;

  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = (state == S_WRITE) ? dst_out : src_out;
  assign mem_wdata = cmp_word;
  assign rd_fire   = (state == S_READ) && mem_ready;
  assign wr_fire   = (state == S_WRITE) && mem_ready;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

  dsc_regs #(.AW(AW), .CW(CW), .DW(DW)) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .cnt_ld        (cnt_in),
    .src_ld        (src_in),
    .dst_ld        (dst_in),
    .cmp_ld        (cmp_in),
    .step          (step),
    .capture       (capture),
    .rd_word       (mem_rdata),
    .cnt_q         (cnt_out),
    .src_q         (src_out),
    .dst_q         (dst_out),
    .cmp_q         (cmp_word),
    .cnt_last      (cnt_last),
    .ld_zero       (ld_zero),
    .ld_misaligned (ld_misaligned)
  );

  dsc_cmp #(.DW(DW)) i_cmp (
    .rd_word  (mem_rdata),
    .cmp_word (cmp_word),
    .dup_hit  (dup_hit)
  );

  dsc_seq i_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .ld_zero       (ld_zero),
    .ld_misaligned (ld_misaligned),
    .rd_fire       (rd_fire),
    .wr_fire       (wr_fire),
    .dup_hit       (dup_hit),
    .cnt_last      (cnt_last),
    .state         (state),
    .load          (load),
    .capture       (capture),
    .step          (step),
    .end_code      (end_code)
  );

  // R6: a stalled request holds its address, direction and data
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7: done never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a duplicate read ends the copy at once
  a_r3_dup_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && dup_hit) |=>
      (done && end_code == 2'd2 && !mem_req));

  // R3: a moved word becomes the compare word and is the next write data
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && !dup_hit) |=>
      (mem_we && mem_wdata == $past(mem_rdata)));

  // R5: a misaligned start makes no request
  a_r5_align: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (src_in[0] || dst_in[0])) |=>
      (done && end_code == 2'd3 && !mem_req));

  // R4: a count-zero end reports an empty count
  a_r4_zero_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && end_code == 2'd1) |-> (cnt_out == '0));
endmodule

// File: tb/test_dupstop_copier.sv
module test_dupstop_copier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cnt_in = '0;
  logic [31:0] src_in = '0, dst_in = '0;
  logic [15:0] cmp_in = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic        busy, done;
  logic [1:0]  end_code;
  logic [15:0] cnt_out;
  logic [31:0] src_out, dst_out;

  always #10 clk = ~clk;

  dupstop_copier i_dupstop_copier (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in),
    .src_in(src_in), .dst_in(dst_in), .cmp_in(cmp_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .end_code(end_code), .cnt_out(cnt_out),
    .src_out(src_out), .dst_out(dst_out)
  );

  logic [15:0] mem [512];
  logic [15:0] exp_mem [512];
  int n_checks = 0, n_fail = 0;
  int rd_n = 0, wr_n = 0, done_n = 0;
  bit done_wide = 0, prev_done = 0, rand_ready = 0;
  int exp_cnt, exp_code, exp_rd, exp_wr;
  logic [31:0] exp_src, exp_dst;

  function automatic int widx(input logic [31:0] a);
    return int'(a[9:1]);
  endfunction

  assign mem_rdata = mem[widx(mem_addr)];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[widx(mem_addr)] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_n <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    mem_ready <= rand_ready ? (($urandom % 3) != 0) : 1'b1;
    if (done) done_n <= done_n + 1;
    if (done && prev_done) done_wide <= 1;
    prev_done <= done;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input int c, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] cw);
    logic [15:0] w;
    exp_rd = 0; exp_wr = 0;
    for (int i = 0; i < 512; i++) exp_mem[i] = mem[i];
    if (s[0] || d[0]) exp_code = 3;
    else if (c == 0) exp_code = 1;
    else begin
      exp_code = 1;
      while (c != 0) begin
        w = exp_mem[widx(s)];
        exp_rd++;
        if (w == cw) begin exp_code = 2; break; end
        exp_mem[widx(d)] = w;
        exp_wr++;
        cw = w; s = s + 2; d = d + 2; c = c - 1;
      end
    end
    exp_cnt = c; exp_src = s; exp_dst = d;
  endtask

  task automatic run_case(input int c, input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] cw, input bit poke);
    int d0, r0, w0, guard, bad;
    logic [15:0] hc; logic [31:0] hs, hd; logic [1:0] he;
    model(c, s, d, cw);
    @(negedge clk);
    d0 = done_n; r0 = rd_n; w0 = wr_n; done_wide = 0;
    cnt_in = 16'(c); src_in = s; dst_in = d; cmp_in = cw; start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        if (busy && !done) begin
          cnt_in = 16'h0001; src_in = 32'h0000_0003; dst_in = 32'h0000_0401; start = 1;
        end
        @(negedge clk);
        start = 0;
      end
    end
    guard = 0;
    while (done_n == d0 && guard < 5000) begin @(negedge clk); guard++; end
    check(guard < 5000, "R7 watchdog done", guard, 0);
    check(end_code == 2'(exp_code), "R3 R4 R5 end_code", end_code, exp_code);
    check(cnt_out == 16'(exp_cnt), "R2 R1 cnt_out", cnt_out, exp_cnt);
    check(src_out == exp_src, "R2 R3 src_out", src_out, exp_src);
    check(dst_out == exp_dst, "R2 dst_out", dst_out, exp_dst);
    check(rd_n - r0 == exp_rd, "R6 R4 read count", rd_n - r0, exp_rd);
    check(wr_n - w0 == exp_wr, "R6 R3 write count", wr_n - w0, exp_wr);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, "R2 memory image mismatches", bad, 0);
    hc = cnt_out; hs = src_out; hd = dst_out; he = end_code;
    @(negedge clk);
    check(!done && !busy, "R7 single pulse then idle", {done, busy}, 0);
    @(negedge clk); @(negedge clk);
    check(!done_wide, "R7 done width", done_wide, 0);
    check(hc == cnt_out && hs == src_out && hd == dst_out && he == end_code,
          "R7 results held", {src_out, cnt_out}, {hs, hc});
  endtask

  task automatic fill(input int alpha);
    for (int i = 0; i < 512; i++)
      mem[i] = (alpha == 0) ? 16'(i * 7 + 1) : 16'($urandom % alpha);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) mem[i] = 16'hA5A5;
    #35;
    check(!busy && !done && !mem_req, "R8 control idle", {busy, done, mem_req}, 0);
    check(end_code == 2'd0 && cnt_out == 0 && src_out == 0 && dst_out == 0,
          "R8 regs clear", {end_code, cnt_out}, 0);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    fill(0);
    run_case(0, 32'h0000_0010, 32'h0000_0300, 16'h0, 0);          // R4 zero count
    run_case(5, 32'h0000_0011, 32'h0000_0300, 16'h0, 0);          // R5 odd source
    run_case(0, 32'h0000_0010, 32'h0000_0301, 16'h0, 0);          // R5 priority
    run_case(12, 32'h0000_0010, 32'h0000_0300, mem[8], 0);        // R3 immediate dup
    run_case(1, 32'h0000_0020, 32'h0000_0320, 16'hFFFF, 0);       // R4 count one
    run_case(20, 32'h0000_0040, 32'h0000_0340, 16'hFFFF, 0);      // R2 no dup
    run_case(8, 32'h0001_FFF8, 32'h7FFF_0300, 16'hFFFF, 0);       // R2 carry
    mem[20] = 16'h1234; mem[21] = 16'h1234;
    run_case(10, 32'h0000_0024, 32'h0000_0380, 16'hFFFF, 0);      // R3 mid dup
    rand_ready = 1;
    run_case(15, 32'h0000_0060, 32'h0000_03A0, 16'hFFFF, 1);      // R1 R6 poke
    for (int t = 0; t < 30; t++) begin
      int c; logic [31:0] s, d;
      fill((t % 3 == 0) ? 0 : (2 + t % 5));
      rand_ready = (t % 2) == 1;
      c = $urandom % 65;
      s = ($urandom & 32'hFFFF_0000) | 32'(($urandom % 180) * 2);
      d = ($urandom & 32'hFFFF_0000) | 32'((256 + $urandom % 180) * 2);
      run_case(c, s, d, 16'($urandom % 4), (t % 4) == 0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL R7 global watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule